// File: doc/BRIEF.md
# Double-Buffered Serial Control Register Bank

This block holds a set of control registers in two copies. A serial slave port fills the staging copy, one register per transaction. The live copy feeds the rest of the chip and changes only when a commit takes place. A host can therefore load new settings ahead of time and apply all of them at once. It does this by raising a separate update input, and the serial port never looks at that input.

The update input is not acted on directly. It first passes through a two-flop synchronizer. It is then sampled on the rising edges of a slow sync clock, which is the system clock divided by four. A commit happens at the second sync-clock rise that sees the request. The commit copies every staging register into its live register in one system clock cycle, and a one-cycle status pulse marks it. The update input is level-sensitive. While it stays high, a commit fires at every sync-clock rise, so any staging change reaches the live copy at the next rise. The sync clock is exported so that a host can line up its update pulses.

The serial pins are treated as an asynchronous domain. They are oversampled in the system clock domain. A transaction starts when chip select goes low. It carries an instruction byte and then the data bytes, all shifted in on rising serial-clock edges.

Top module: `dbuf_spi_regbank`

## Requirements
- R1: `sync_clk_o` is low during reset and then repeats the pattern low, high, high, low on consecutive system clocks. It is high after the 2nd and 3rd rising edges that follow reset release, and every 4 edges after that.
- R2: While reset is held, `active_o` is all zero and `commit_o` is low. The staging registers also reset to zero.
- R3: The update input is first delayed by two synchronizer flops and then sampled at each sync-clock rise. A commit happens only at a sync-clock rise whose previous sync-clock rise sampled the update as high. Without a commit, `active_o` holds its value.
- R4: A commit loads every live register from its staging register on the same system clock edge. `commit_o` is high for exactly the one cycle that follows that edge.
- R5: While the update input is held high, a commit fires at every sync-clock rise. A staging change therefore reaches `active_o` at the first sync-clock rise after it lands, with no new pulse.
- R6: The instruction byte is shifted in MSB first. Bit 7 set (1) means read and clear (0) means write, and bits 4:0 give the address. A read transaction changes no register.
- R7: Data bytes arrive MSB first. Register `a` takes `a[1:0]+1` bytes, and the value is right-aligned and zero-extended to 32 bits. Register `i` appears at `active_o[32*i +: 32]`.
- R8: A completed write lands in its staging register on the third system clock edge after the first edge that samples the final serial-clock high level.
- R9: A transaction that ends with chip select rising before the last data bit leaves every register unchanged. This holds whether it ends mid-byte or between bytes.
- R10: A write to an address of NREG or above changes nothing. Bytes that follow a register's final byte are ignored until chip select rises.
- R11: Activity on the update input during a transaction does not disturb the serial shifting.
- R12: A write that lands on the same edge as a commit misses that commit. The live register keeps its old value until the next commit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_cs_n | input | 1 | Serial chip select, active low, asynchronous |
| spi_sclk | input | 1 | Serial clock, data taken on rising edge |
| spi_mosi | input | 1 | Serial data into the block |
| upd_req | input | 1 | Level-sensitive commit request, asynchronous |
| sync_clk_o | output | 1 | Divide-by-4 sync clock |
| commit_o | output | 1 | One-cycle pulse after each commit |
| active_o | output | NREG*32 | Live registers, register i at bits 32*i+31:32*i |

## Verification
The two functions that can fall on one system clock edge are a serial write landing in a staging register and a commit copying the staging bank. The bench holds the update input high, or places short update pulses, and shifts the finishing serial-clock edge through every phase of the divide-by-4 sync clock. This makes the write land before, on, and after a commit edge. A behavioural model, stepped on each edge, applies the commit before the write and so predicts whether the new value is copied now or at the next commit. `active_o` and `commit_o` are compared with it on every clock.

// File: rtl/dbuf_pkg.sv
package dbuf_pkg;

    localparam int BYTE_W    = 8;
    localparam int ADDR_W    = 5;
    localparam int MAX_BYTES = 4;
    localparam int REG_W     = BYTE_W * MAX_BYTES;
    localparam int LEN_W     = $clog2(MAX_BYTES);
    localparam int BIT_W     = $clog2(BYTE_W);

    typedef enum logic [1:0] {
        RX_INSTR,
        RX_DATA,
        RX_DRAIN
    } rx_state_e;

    // instruction byte layout, MSB first on the wire
    typedef struct packed {
        logic              rd;
        logic [1:0]        rsvd;
        logic [ADDR_W-1:0] addr;
    } instr_t;

    typedef struct packed {
        logic              vld;
        logic [ADDR_W-1:0] addr;
        logic [REG_W-1:0]  data;
    } wr_req_t;

    // index of the final data byte for a register address (length minus one)
    function automatic logic [LEN_W-1:0] last_byte_idx(input logic [ADDR_W-1:0] a);
        return a[LEN_W-1:0];
    endfunction

endpackage

// File: rtl/dbuf_sync_div.sv
module dbuf_sync_div #(
    parameter int DIV_W = 2
) (
    input  logic clk,
    input  logic rst,
    output logic sync_clk,
    output logic sync_rise
);
    localparam logic [DIV_W-1:0] RISE_AT = DIV_W'((1 << (DIV_W - 1)) - 1);

    logic [DIV_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_q + 1'b1;
    end

    assign sync_clk  = cnt_q[DIV_W-1];
    assign sync_rise = (cnt_q == RISE_AT);

    // R1
    rise_then_high_chk: assert property (@(posedge clk) disable iff (rst)
        sync_rise |=> sync_clk);

    // R1
    high_two_cycles_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sync_clk) |=> $stable(sync_clk));

endmodule

// File: rtl/dbuf_upd_sync.sv
module dbuf_upd_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic upd_async,
    input  logic sync_rise,
    output logic commit_en,
    output logic commit_pulse
);
    logic [SYNC_STAGES-1:0] meta_q;
    logic                   armed_q;
    logic                   upd_s;

    assign upd_s     = meta_q[SYNC_STAGES-1];
    assign commit_en = sync_rise & armed_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q       <= '0;
            armed_q      <= 1'b0;
            commit_pulse <= 1'b0;
        end else begin
            meta_q       <= {meta_q[SYNC_STAGES-2:0], upd_async};
            commit_pulse <= commit_en;
            if (sync_rise) armed_q <= upd_s;
        end
    end

    // R3
    commit_on_rise_chk: assert property (@(posedge clk) disable iff (rst)
        commit_pulse |-> $past(sync_rise));

    // R3
    unarmed_no_commit_chk: assert property (@(posedge clk) disable iff (rst)
        (sync_rise && !armed_q) |=> !commit_pulse);

    // R4
    single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        commit_pulse |=> !commit_pulse);

endmodule

// File: rtl/dbuf_spi_rx.sv
module dbuf_spi_rx
    import dbuf_pkg::*;
#(
    parameter int NREG = 8
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    cs_n,
    input  logic    sclk,
    input  logic    mosi,
    output wr_req_t wr
);
    logic [1:0]       cs_q;
    logic [2:0]       sclk_q;
    logic [1:0]       mosi_q;
    logic             cs_idle;
    logic             sclk_rise;
    logic             bit_in;

    rx_state_e        state_q;
    logic [BIT_W-1:0] bit_cnt_q;
    logic [BYTE_W-2:0] shift_q;
    instr_t           instr_q;
    logic [LEN_W-1:0] byte_idx_q;
    logic [REG_W-1:0] acc_q;
    wr_req_t          wr_q;

    logic [BYTE_W-1:0] byte_now;
    logic [REG_W-1:0]  acc_next;
    logic              byte_done;
    logic              last_byte;
    logic              addr_ok;

    assign cs_idle   = cs_q[1];
    assign sclk_rise = sclk_q[1] & ~sclk_q[2];
    assign bit_in    = mosi_q[1];

    assign byte_now  = {shift_q, bit_in};
    assign byte_done = sclk_rise && (bit_cnt_q == BIT_W'(BYTE_W - 1));
    assign acc_next  = {acc_q[REG_W-BYTE_W-1:0], byte_now};
    assign last_byte = (byte_idx_q == last_byte_idx(instr_q.addr));
    assign addr_ok   = (int'(instr_q.addr) < NREG);

    // pin oversampling into the system clock domain
    always_ff @(posedge clk) begin
        if (rst) begin
            cs_q   <= '1;
            sclk_q <= '0;
            mosi_q <= '0;
        end else begin
            cs_q   <= {cs_q[0], cs_n};
            sclk_q <= {sclk_q[1:0], sclk};
            mosi_q <= {mosi_q[0], mosi};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= RX_INSTR;
            bit_cnt_q  <= '0;
            shift_q    <= '0;
            instr_q    <= '0;
            byte_idx_q <= '0;
            acc_q      <= '0;
            wr_q       <= '0;
        end else begin
            wr_q.vld <= 1'b0;
            if (cs_idle) begin
                state_q   <= RX_INSTR;
                bit_cnt_q <= '0;
            end else if (sclk_rise) begin
                shift_q   <= byte_now[BYTE_W-2:0];
                bit_cnt_q <= bit_cnt_q + 1'b1;
                if (byte_done) begin
                    unique case (state_q)
                        RX_INSTR: begin
                            instr_q    <= instr_t'(byte_now);
                            byte_idx_q <= '0;
                            acc_q      <= '0;
                            state_q    <= RX_DATA;
                        end
                        RX_DATA: begin
                            acc_q <= acc_next;
                            if (last_byte) begin
                                wr_q.vld  <= !instr_q.rd && addr_ok;
                                wr_q.addr <= instr_q.addr;
                                wr_q.data <= acc_next;
                                state_q   <= RX_DRAIN;
                            end else begin
                                byte_idx_q <= byte_idx_q + 1'b1;
                            end
                        end
                        default: state_q <= RX_DRAIN;
                    endcase
                end
            end
        end
    end

    assign wr = wr_q;

    // R9
    wr_while_selected_chk: assert property (@(posedge clk) disable iff (rst)
        wr_q.vld |-> !$past(cs_idle));

    // R6
    wr_never_read_chk: assert property (@(posedge clk) disable iff (rst)
        wr_q.vld |-> !$past(instr_q.rd));

endmodule

// File: rtl/dbuf_reg_pair.sv
module dbuf_reg_pair
    import dbuf_pkg::*;
#(
    parameter int NREG = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  wr_req_t                 wr,
    input  logic                    commit_en,
    output logic [NREG*REG_W-1:0]   active_flat
);
    logic [NREG*REG_W-1:0] ser_flat;

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        logic [REG_W-1:0] ser_r;
        logic [REG_W-1:0] act_r;

        always_ff @(posedge clk) begin
            if (rst) begin
                ser_r <= '0;
                act_r <= '0;
            end else begin
                if (wr.vld && (wr.addr == ADDR_W'(g))) ser_r <= wr.data;
                if (commit_en)                          act_r <= ser_r;
            end
        end

        assign ser_flat[g*REG_W +: REG_W]    = ser_r;
        assign active_flat[g*REG_W +: REG_W] = act_r;
    end

    // R4
    copy_all_chk: assert property (@(posedge clk) disable iff (rst)
        commit_en |=> (active_flat == $past(ser_flat)));

    // R3
    hold_no_commit_chk: assert property (@(posedge clk) disable iff (rst)
        !commit_en |=> $stable(active_flat));

endmodule

// File: rtl/dbuf_spi_regbank.sv
module dbuf_spi_regbank
    import dbuf_pkg::*;
#(
    parameter int NREG        = 8,
    parameter int DIV_W       = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  spi_cs_n,
    input  logic                  spi_sclk,
    input  logic                  spi_mosi,
    input  logic                  upd_req,
    output logic                  sync_clk_o,
    output logic                  commit_o,
    output logic [NREG*REG_W-1:0] active_o
);
    logic    sync_rise;
    logic    commit_en;
    wr_req_t wr;

    dbuf_sync_div #(.DIV_W(DIV_W)) u_div (
        .clk       (clk),
        .rst       (rst),
        .sync_clk  (sync_clk_o),
        .sync_rise (sync_rise)
    );

    dbuf_upd_sync #(.SYNC_STAGES(SYNC_STAGES)) u_upd (
        .clk          (clk),
        .rst          (rst),
        .upd_async    (upd_req),
        .sync_rise    (sync_rise),
        .commit_en    (commit_en),
        .commit_pulse (commit_o)
    );

    dbuf_spi_rx #(.NREG(NREG)) u_rx (
        .clk  (clk),
        .rst  (rst),
        .cs_n (spi_cs_n),
        .sclk (spi_sclk),
        .mosi (spi_mosi),
        .wr   (wr)
    );

    dbuf_reg_pair #(.NREG(NREG)) u_regs (
        .clk         (clk),
        .rst         (rst),
        .wr          (wr),
        .commit_en   (commit_en),
        .active_flat (active_o)
    );

endmodule

// File: tb/dbuf_spi_regbank_bench.sv
`timescale 1ns/1ps
module dbuf_spi_regbank_bench;
    import dbuf_pkg::*;

    localparam int NREG = 8;
    localparam int AW   = NREG * REG_W;

    logic clk = 1'b0, rst = 1'b1;
    logic cs_n = 1'b1, sclk = 1'b0, mosi = 1'b0, upd = 1'b0;
    logic sync_clk, commit;
    logic [AW-1:0] act;

    always #2 clk = ~clk;

    dbuf_spi_regbank #(.NREG(NREG)) u_dbuf_spi_regbank (
        .clk(clk), .rst(rst), .spi_cs_n(cs_n), .spi_sclk(sclk), .spi_mosi(mosi),
        .upd_req(upd), .sync_clk_o(sync_clk), .commit_o(commit), .active_o(act)
    );

    int n_checks = 0, n_fail = 0;
    bit finished = 1'b0;

    // behavioural reference model
    int k = 0;
    bit uq[$];
    bit armed_m = 1'b0, commit_m = 1'b0;
    logic [REG_W-1:0] ser_m [NREG];
    logic [REG_W-1:0] act_m [NREG];
    int pend_k = -1, pend_addr = 0;
    logic [REG_W-1:0] pend_val = '0;
    logic [AW-1:0] exp_flat;

    always @(posedge clk) begin : model
        bit us;
        if (rst) begin
            k = 0; uq.delete(); armed_m = 0; commit_m = 0; pend_k = -1;
            for (int i = 0; i < NREG; i++) begin ser_m[i] = '0; act_m[i] = '0; end
        end else begin
            k++;
            us = (uq.size() >= 2) ? uq[uq.size()-2] : 1'b0;
            uq.push_back(upd);
            if (uq.size() > 8) void'(uq.pop_front());
            commit_m = 0;
            if (k % 4 == 2) begin
                if (armed_m) begin
                    for (int i = 0; i < NREG; i++) act_m[i] = ser_m[i];
                    commit_m = 1;
                end
                armed_m = us;
            end
            if (pend_k == k) begin ser_m[pend_addr] = pend_val; pend_k = -1; end
        end
    end

    task automatic chk(input string what, input logic [AW-1:0] got, input logic [AW-1:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", what, got, exp);
        end
    endtask

    // every-clock comparison, away from the active edge
    always @(negedge clk) begin
        if (!rst && !finished) begin
            for (int i = 0; i < NREG; i++) exp_flat[i*REG_W +: REG_W] = act_m[i];
            chk("R4 R5 R8 R12 active_o vs model", act, exp_flat);
            chk("R3 R4 commit_o vs model", AW'(commit), AW'(commit_m));
            chk("R1 sync_clk_o vs model", AW'(sync_clk), AW'((k % 4) >= 2));
        end
    end

    function automatic logic [REG_W-1:0] reg_of(input int i);
        return act[i*REG_W +: REG_W];
    endfunction

    task automatic spi_xfer(input logic [47:0] bytes, input int nb, input int stop_bits);
        logic [7:0] ins;
        logic [REG_W-1:0] val;
        int len, total, last_bit;
        bit do_wr;
        ins = bytes[47:40];
        len = int'(ins[1:0]) + 1;
        do_wr = !ins[7] && (int'(ins[4:0]) < NREG) && (nb >= 1 + len);
        last_bit = 8 * (1 + len);
        total = (stop_bits < 0) ? 8 * nb : stop_bits;
        val = '0;
        for (int j = 0; j < len; j++) val = {val[REG_W-9:0], bytes[39-8*j -: 8]};
        cs_n = 1'b0;
        repeat (4) @(negedge clk);
        for (int b = 0; b < total; b++) begin
            mosi = bytes[47-b];
            repeat (4) @(negedge clk);
            sclk = 1'b1;
            if (do_wr && (b + 1 == last_bit)) begin
                pend_k = k + 4; pend_addr = int'(ins[4:0]); pend_val = val;
            end
            repeat (4) @(negedge clk);
            sclk = 1'b0;
        end
        repeat (4) @(negedge clk);
        cs_n = 1'b1;
        repeat (8) @(negedge clk);
    endtask

    task automatic pulse(input int n);
        upd = 1'b1;
        repeat (n) @(negedge clk);
        upd = 1'b0;
        repeat (16) @(negedge clk);
    endtask

    task automatic finish_run();
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog expired before the sequence completed");
            finish_run();
        end
    end

    initial begin : stim
        logic [7:0] pat;
        logic [AW-1:0] snap;
        repeat (5) @(negedge clk);
        // R2 reset state
        chk("R2 active_o in reset", act, '0);
        chk("R2 commit_o in reset", AW'(commit), '0);
        chk("R1 sync_clk_o in reset", AW'(sync_clk), '0);
        rst = 1'b0;
        pat = '0;
        for (int i = 0; i < 8; i++) begin @(negedge clk); pat = {pat[6:0], sync_clk}; end
        chk("R1 sync clock pattern", AW'(pat), AW'(8'b0110_0110));

        // R7 four-byte register, R3 no commit without update
        spi_xfer({8'h03, 32'hA1B2_C3D4, 8'h00}, 5, -1);
        repeat (16) @(negedge clk);
        chk("R3 no commit without update", AW'(reg_of(3)), '0);
        pulse(4);
        chk("R7 R4 reg3 four bytes", AW'(reg_of(3)), AW'(32'hA1B2_C3D4));

        // R7 short registers, R10 trailing bytes ignored
        spi_xfer({8'h00, 8'h5A, 8'h77, 8'h88, 16'h0}, 4, -1);
        spi_xfer({8'h01, 8'h12, 8'h34, 24'h0}, 3, -1);
        pulse(4);
        chk("R7 R10 reg0 one byte", AW'(reg_of(0)), AW'(32'h0000_005A));
        chk("R7 reg1 two bytes", AW'(reg_of(1)), AW'(32'h0000_1234));

        // R6 read changes nothing
        spi_xfer({8'h82, 8'h11, 8'h22, 8'h33, 16'h0}, 4, -1);
        pulse(4);
        chk("R6 read leaves reg2", AW'(reg_of(2)), '0);

        // R10 out-of-range addresses
        snap = act;
        spi_xfer({8'h09, 8'hDE, 8'hAD, 24'h0}, 3, -1);
        spi_xfer({8'h1A, 8'h01, 8'h02, 8'h03, 16'h0}, 4, -1);
        pulse(4);
        chk("R10 out-of-range write ignored", act, snap);

        // R9 aborts mid-byte and between bytes
        spi_xfer({8'h03, 32'h1122_3344, 8'h00}, 5, 19);
        spi_xfer({8'h03, 32'h5566_7788, 8'h00}, 5, 24);
        pulse(4);
        chk("R9 aborted writes leave reg3", AW'(reg_of(3)), AW'(32'hA1B2_C3D4));

        // R11 update toggling during a transaction
        fork
            spi_xfer({8'h01, 8'hBE, 8'hEF, 24'h0}, 3, -1);
            begin repeat (20) @(negedge clk); upd = 1'b1; repeat (6) @(negedge clk); upd = 1'b0; end
        join
        pulse(4);
        chk("R11 write intact with update activity", AW'(reg_of(1)), AW'(32'h0000_BEEF));

        // R5 level-held update follows every change
        upd = 1'b1;
        repeat (16) @(negedge clk);
        spi_xfer({8'h02, 8'hC0, 8'hFF, 8'hEE, 16'h0}, 4, -1);
        chk("R5 reg2 follows while held", AW'(reg_of(2)), AW'(32'h00C0_FFEE));
        spi_xfer({8'h00, 8'h99, 32'h0}, 2, -1);
        chk("R5 reg0 follows while held", AW'(reg_of(0)), AW'(32'h0000_0099));

        // R12 write landing at every sync phase while held
        for (int ph = 0; ph < 8; ph++) begin
            repeat (ph) @(negedge clk);
            spi_xfer({8'h02, 8'(ph), 8'(ph + 1), 8'(ph + 2), 16'h0}, 4, -1);
        end
        chk("R12 R5 reg2 after sweep", AW'(reg_of(2)), AW'({8'h00, 8'd7, 8'd8, 8'd9}));
        upd = 1'b0;
        repeat (16) @(negedge clk);

        // R12 short update pulses near the write landing
        for (int ph = 0; ph < 8; ph++) begin
            fork
                spi_xfer({8'h00, 8'(8'h40 + ph), 32'h0}, 2, -1);
                begin repeat (126 + ph) @(negedge clk); upd = 1'b1; repeat (2) @(negedge clk); upd = 1'b0; end
            join
        end
        pulse(4);
        chk("R12 reg0 after pulse sweep", AW'(reg_of(0)), AW'(32'h0000_0047));
        finish_run();
    end

endmodule